// File: doc/BRIEF.md
# Calendar Clockwatch with BCD Year

This block keeps wall-clock time in calendar form rather than as a running seconds count. One 32-bit word packs the second, minute, hour, weekday, day of month and month. A separate 16-bit word holds the year as four BCD digits, with the century in the upper byte and the year within the century in the lower byte. Each one-second tick advances the time while the clockwatch enable is set. Every carry is applied in the same tick: month lengths, February 29 in leap years, the weekday wrap, and the carry from December into the next year and century.

Software sets the time in two writes. It first writes the year into a staging register, then writes the time word, and that second write commits both words at once. A second pair of registers holds an alarm date and time. When a tick moves the clock onto exactly that date and time, a sticky alarm flag is raised. The flag stays high until software clears it. All access goes through a plain single-cycle register port with a registered read path.

Top module: `cal_clockwatch`

## Requirements
- R1: After synchronous reset the time word reads 0x021E0000 (month 1, day 1, weekday 7, 00:00:00), the year word reads 0x2000, the enable is clear and the alarm flag is low.
- R2: Time word layout: second in bits 5:0 (0-59), minute in 11:6 (0-59), hour in 16:12 (0-23), weekday in 19:17 (1-7, 1 = Sunday), day of month in 24:20 (1-31), month in 28:25 (1-12, 1 = January). Bits 31:29 are zero. Year word: BCD year-in-century in bits 7:0 and BCD century in bits 15:8.
- R3: On an enabled tick the second increments. The value 59 wraps to 0 and carries into the minute, 59 minutes carry into the hour, and hour 23 wraps to 0 and carries into the day.
- R4: On each day carry the weekday increments, and 7 wraps to 1.
- R5: On a day carry the day of month wraps to 1 after the last day of its month. April, June, September and November have 30 days, and the other months except February have 31. February has 29 days when the BCD year-in-century is divisible by 4 and is non-zero, or when it is 00 and the century is divisible by 4. Otherwise February has 28 days.
- R6: When month 12 wraps, the month becomes 1 and the BCD year increments, carrying into the century. Year 9999 wraps to 0000.
- R7: A write to offset 0x38 only stages a year, and the year word does not change. A write to offset 0x08 loads the time word from the write data and the year word from the staged value in the same cycle. A load in the same cycle as a tick wins, and that tick is discarded.
- R8: The alarm flag is set by a tick after which the time word equals the match word (offset 0x04) and the year word equals the year match (offset 0x34). Once set, the flag stays high through further ticks. Writing 1 in bit 0 at offset 0x1C clears it. A mismatch in the year alone prevents the alarm.
- R9: Reads are registered, so bus_rdata shows the register at bus_addr one cycle later. The time is at 0x00, the year at 0x30, the matches at 0x04 and 0x34, control at 0x0C (enable in bit 26) and the alarm flag at 0x14 bit 0. Any other offset reads 0.
- R10: While control bit 26 is clear, ticks are ignored and the time and year words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| bus_addr | input | ADDR_W | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
The in-line assertions check four things on every cycle. The fields stay in their legal ranges across any tick, and the BCD digits stay decimal. A disabled clock does not move unless it is loaded, a load lands exactly the written word, and a raised alarm survives until its clear. Only the bench scenarios can show that the rollover lands on the right value. Those scenarios cover the 30- and 31-day months, the leap and non-leap Februaries including the century rules, the 9999 wrap, the precedence of a load over a tick, and an alarm lost to a year mismatch alone.

// File: rtl/cal_pkg.sv
package cal_pkg;
  // Packed time word, second in the least significant bits.
  typedef struct packed {
    logic [2:0] pad;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  typedef struct packed {
    logic [3:0] c_hi;
    logic [3:0] c_lo;
    logic [3:0] y_hi;
    logic [3:0] y_lo;
  } bcd_year_t;

  localparam logic [31:0] TIME_RST = 32'h021E_0000;
  localparam logic [15:0] YEAR_RST = 16'h2000;
  localparam int          EN_BIT   = 26;

  localparam logic [7:0] OFS_TIME   = 8'h00;
  localparam logic [7:0] OFS_TMATCH = 8'h04;
  localparam logic [7:0] OFS_TLOAD  = 8'h08;
  localparam logic [7:0] OFS_CTRL   = 8'h0C;
  localparam logic [7:0] OFS_RAW    = 8'h14;
  localparam logic [7:0] OFS_CLR    = 8'h1C;
  localparam logic [7:0] OFS_YEAR   = 8'h30;
  localparam logic [7:0] OFS_YMATCH = 8'h34;
  localparam logic [7:0] OFS_YLOAD  = 8'h38;

  function automatic logic time_ok(cal_time_t t);
    return (t.sec < 6'd60) && (t.min < 6'd60) && (t.hour < 5'd24) &&
           (t.wday != 3'd0) && (t.mday != 5'd0) &&
           (t.mon != 4'd0) && (t.mon < 4'd13);
  endfunction

  function automatic logic bcd_ok(bcd_year_t y);
    return (y.c_hi < 4'd10) && (y.c_lo < 4'd10) &&
           (y.y_hi < 4'd10) && (y.y_lo < 4'd10);
  endfunction
endpackage

// File: rtl/cal_year_inc.sv
module cal_year_inc
  import cal_pkg::*;
(
  input  bcd_year_t cur,
  output bcd_year_t nxt,
  output logic      leap
);
  logic [4:0] ysum, csum;

  // Divisibility by 4 of a two-digit BCD value: (2*tens + ones) mod 4.
  always_comb begin
    ysum = {cur.y_hi, 1'b0} + {1'b0, cur.y_lo};
    csum = {cur.c_hi, 1'b0} + {1'b0, cur.c_lo};
    if ({cur.y_hi, cur.y_lo} != 8'h00) leap = (ysum[1:0] == 2'd0);
    else                               leap = (csum[1:0] == 2'd0);
  end

  always_comb begin
    nxt = cur;
    if (cur.y_lo != 4'd9) nxt.y_lo = cur.y_lo + 4'd1;
    else begin
      nxt.y_lo = 4'd0;
      if (cur.y_hi != 4'd9) nxt.y_hi = cur.y_hi + 4'd1;
      else begin
        nxt.y_hi = 4'd0;
        if (cur.c_lo != 4'd9) nxt.c_lo = cur.c_lo + 4'd1;
        else begin
          nxt.c_lo = 4'd0;
          if (cur.c_hi != 4'd9) nxt.c_hi = cur.c_hi + 4'd1;
          else                  nxt.c_hi = 4'd0;
        end
      end
    end
  end
endmodule

// File: rtl/cal_date_adv.sv
module cal_date_adv
  import cal_pkg::*;
(
  input  cal_time_t cur,
  input  logic      leap,
  output cal_time_t nxt,
  output logic      year_carry
);
  logic [4:0] last_day;

  always_comb begin
    case (cur.mon)
      4'd2:                      last_day = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   last_day = 5'd30;
      default:                   last_day = 5'd31;
    endcase
  end

  always_comb begin
    nxt        = cur;
    year_carry = 1'b0;
    if (cur.sec != 6'd59) nxt.sec = cur.sec + 6'd1;
    else begin
      nxt.sec = 6'd0;
      if (cur.min != 6'd59) nxt.min = cur.min + 6'd1;
      else begin
        nxt.min = 6'd0;
        if (cur.hour != 5'd23) nxt.hour = cur.hour + 5'd1;
        else begin
          nxt.hour = 5'd0;
          nxt.wday = (cur.wday == 3'd7) ? 3'd1 : cur.wday + 3'd1;
          if (cur.mday != last_day) nxt.mday = cur.mday + 5'd1;
          else begin
            nxt.mday = 5'd1;
            if (cur.mon != 4'd12) nxt.mon = cur.mon + 4'd1;
            else begin
              nxt.mon    = 4'd1;
              year_carry = 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cal_clockwatch.sv
module cal_clockwatch
  import cal_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              alarm_o
);
  cal_time_t time_q, mtime_q, time_nx;
  bcd_year_t year_q, myear_q, stage_q, year_inc, year_nx;
  logic      en_q, alarm_q, leap, carry;
  logic [31:0] rdata_q;

  logic wr_tload, wr_yload, wr_tmatch, wr_ymatch, wr_ctrl, wr_clr, tick_go;

  assign wr_tload  = bus_wr && (bus_addr == ADDR_W'(OFS_TLOAD));
  assign wr_yload  = bus_wr && (bus_addr == ADDR_W'(OFS_YLOAD));
  assign wr_tmatch = bus_wr && (bus_addr == ADDR_W'(OFS_TMATCH));
  assign wr_ymatch = bus_wr && (bus_addr == ADDR_W'(OFS_YMATCH));
  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_clr    = bus_wr && (bus_addr == ADDR_W'(OFS_CLR)) && bus_wdata[0];
  assign tick_go   = sec_tick && en_q && !wr_tload;

  cal_year_inc u_year (.cur(year_q), .nxt(year_inc), .leap(leap));
  cal_date_adv u_date (.cur(time_q), .leap(leap), .nxt(time_nx), .year_carry(carry));

  assign year_nx = carry ? year_inc : year_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q  <= cal_time_t'(TIME_RST);
      year_q  <= bcd_year_t'(YEAR_RST);
      stage_q <= bcd_year_t'(YEAR_RST);
      mtime_q <= '0;
      myear_q <= '0;
      en_q    <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      if (wr_yload)  stage_q <= bus_wdata[15:0];
      if (wr_tmatch) mtime_q <= bus_wdata;
      if (wr_ymatch) myear_q <= bus_wdata[15:0];
      if (wr_ctrl)   en_q    <= bus_wdata[EN_BIT];
      if (wr_tload) begin
        time_q <= bus_wdata;
        year_q <= stage_q;
      end else if (tick_go) begin
        time_q <= time_nx;
        year_q <= year_nx;
      end
      if (tick_go && (time_nx == mtime_q) && (year_nx == myear_q)) alarm_q <= 1'b1;
      else if (wr_clr)                                             alarm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (bus_addr)
        ADDR_W'(OFS_TIME):   rdata_q <= time_q;
        ADDR_W'(OFS_TMATCH): rdata_q <= mtime_q;
        ADDR_W'(OFS_CTRL):   rdata_q <= {5'd0, en_q, 26'd0};
        ADDR_W'(OFS_RAW):    rdata_q <= {31'd0, alarm_q};
        ADDR_W'(OFS_YEAR):   rdata_q <= {16'd0, year_q};
        ADDR_W'(OFS_YMATCH): rdata_q <= {16'd0, myear_q};
        default:             rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign alarm_o   = alarm_q;

  // R2: a tick from a legal time yields a legal time
  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_go && time_ok(time_q)) |=> time_ok(time_q));

  // R6: the year digits stay decimal across a tick
  p_bcd_r6: assert property (@(posedge clk) disable iff (rst)
    (tick_go && bcd_ok(year_q)) |=> bcd_ok(year_q));

  // R7: a load lands exactly the written word
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    wr_tload |=> (time_q == $past(bus_wdata)));

  // R8: the alarm holds until an explicit clear
  p_alarm_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (alarm_q && !wr_clr) |=> alarm_q);

  // R10: disabled clock does not move without a load
  p_hold_off_r10: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !wr_tload) |=> ($stable(time_q) && $stable(year_q)));
endmodule

// File: tb/cal_clockwatch_tb.sv
`timescale 1ns/1ps
module cal_clockwatch_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_tick = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        alarm_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cal_clockwatch #(.ADDR_W(8)) u_dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_o(alarm_o)
  );

  function automatic logic [31:0] mk(int mon, int mday, int wday, int hour, int mn, int sec);
    return (32'(mon) << 25) | (32'(mday) << 20) | (32'(wday) << 17) |
           (32'(hour) << 12) | (32'(mn) << 6) | 32'(sec);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic load(logic [15:0] y, logic [31:0] t);
    wr(8'h38, {16'd0, y});
    wr(8'h08, t);
  endtask

  // Load, tick once, compare both words.
  task automatic step_chk(string req, logic [15:0] y0, logic [31:0] t0,
                          logic [15:0] y1, logic [31:0] t1);
    logic [31:0] v;
    load(y0, t0);
    tick();
    rd(8'h00, v); chk(req, v, t1);
    rd(8'h30, v); chk(req, v, {16'd0, y1});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 time", v, 32'h021E_0000);
    rd(8'h30, v); chk("R1 year", v, 32'h0000_2000);
    rd(8'h0C, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h14, v); chk("R1 raw", v, 32'h0);
    chk("R1 alarm_o", {31'd0, alarm_o}, 32'h0);
    rd(8'h3C, v); chk("R9 unmapped", v, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    repeat (3) tick();
    rd(8'h00, v); chk("R10 time held", v, 32'h021E_0000);
    rd(8'h30, v); chk("R10 year held", v, 32'h0000_2000);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(8'h0C, 32'h0400_0000);
    rd(8'h0C, v); chk("R9 ctrl", v, 32'h0400_0000);
    tick();
    rd(8'h00, v); chk("R2 second field", v, 32'h021E_0001);
  endtask

  task automatic t_carry();
    step_chk("R3 second", 16'h2024, mk(3,5,3,10,0,58), 16'h2024, mk(3,5,3,10,0,59));
    step_chk("R3 minute", 16'h2024, mk(3,5,3,10,7,59), 16'h2024, mk(3,5,3,10,8,0));
    step_chk("R3 hour",   16'h2024, mk(3,5,3,10,59,59), 16'h2024, mk(3,5,3,11,0,0));
    step_chk("R3 day",    16'h2024, mk(3,5,3,23,59,59), 16'h2024, mk(3,6,4,0,0,0));
  endtask

  task automatic t_wday();
    step_chk("R4 wrap", 16'h2024, mk(1,10,7,23,59,59), 16'h2024, mk(1,11,1,0,0,0));
  endtask

  task automatic t_month_len();
    step_chk("R5 leap feb", 16'h2024, mk(2,28,4,23,59,59), 16'h2024, mk(2,29,5,0,0,0));
    step_chk("R5 feb29 end", 16'h2024, mk(2,29,5,23,59,59), 16'h2024, mk(3,1,6,0,0,0));
    step_chk("R5 plain feb", 16'h2023, mk(2,28,3,23,59,59), 16'h2023, mk(3,1,4,0,0,0));
    step_chk("R5 century 2100", 16'h2100, mk(2,28,1,23,59,59), 16'h2100, mk(3,1,2,0,0,0));
    step_chk("R5 century 2000", 16'h2000, mk(2,28,2,23,59,59), 16'h2000, mk(2,29,3,0,0,0));
    step_chk("R5 april", 16'h2024, mk(4,30,3,23,59,59), 16'h2024, mk(5,1,4,0,0,0));
    step_chk("R5 july 30", 16'h2024, mk(7,30,3,23,59,59), 16'h2024, mk(7,31,4,0,0,0));
  endtask

  task automatic t_year();
    step_chk("R6 decade", 16'h2019, mk(12,31,3,23,59,59), 16'h2020, mk(1,1,4,0,0,0));
    step_chk("R6 century", 16'h2099, mk(12,31,5,23,59,59), 16'h2100, mk(1,1,6,0,0,0));
    step_chk("R6 wrap 9999", 16'h9999, mk(12,31,6,23,59,59), 16'h0000, mk(1,1,7,0,0,0));
  endtask

  task automatic t_load();
    logic [31:0] v;
    load(16'h2024, mk(5,5,5,5,5,5));
    wr(8'h38, 32'h0000_1987);
    rd(8'h30, v); chk("R7 stage only", v, 32'h0000_2024);
    @(negedge clk);
    bus_addr = 8'h08; bus_wdata = mk(8,8,2,8,8,8); bus_wr = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; sec_tick = 1'b0;
    rd(8'h00, v); chk("R7 load wins", v, mk(8,8,2,8,8,8));
    rd(8'h30, v); chk("R7 year commit", v, 32'h0000_1987);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    wr(8'h04, mk(6,1,2,12,0,1));
    wr(8'h34, 32'h0000_2031);
    load(16'h2030, mk(6,1,2,12,0,0));
    tick();
    chk("R8 year mismatch", {31'd0, alarm_o}, 32'h0);
    wr(8'h34, 32'h0000_2030);
    rd(8'h34, v); chk("R9 year match read", v, 32'h0000_2030);
    load(16'h2030, mk(6,1,2,12,0,0));
    chk("R8 before match", {31'd0, alarm_o}, 32'h0);
    tick();
    chk("R8 set", {31'd0, alarm_o}, 32'h1);
    rd(8'h14, v); chk("R8 raw", v, 32'h1);
    tick();
    chk("R8 sticky", {31'd0, alarm_o}, 32'h1);
    wr(8'h1C, 32'h0);
    chk("R8 clear needs bit0", {31'd0, alarm_o}, 32'h1);
    wr(8'h1C, 32'h1);
    chk("R8 cleared", {31'd0, alarm_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_enable();
    t_carry();
    t_wday();
    t_month_len();
    t_year();
    t_load();
    t_alarm();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule